// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mixed Edge and Level Sources

The controller gathers a set of interrupt request lines into one status word and masks that word with a software-owned enable word. The masked result, called pending, drives a single interrupt line to the processor. A vector register names the lowest-numbered pending line. When nothing is pending, the vector reads as all ones. An elaboration-time mask sets each request line as edge-sensitive (a rising edge latches the bit) or level-sensitive (the bit tracks the line).

Software reaches the controller through a plain word-addressed bus with a write strobe and a read path with no wait cycles. Eight word offsets are decoded:

| Offset | Register | Effect of a write |
|---|---|---|
| 0 | status | Replaced by the write data. |
| 1 | pending | Read only. |
| 2 | enable | Replaced by the write data. |
| 3 | acknowledge | Clears status bits. |
| 4 | set-enable | Sets enable bits. |
| 5 | clear-enable | Clears enable bits. |
| 6 | vector | Read only. |
| 7 | master control | Stores the low two bits. |

Master control has two bits:
- Bit 0 lets the interrupt line reach the processor.
- Bit 1 lets the request lines update status.

While bit 1 is clear, any change on the request lines mutes the interrupt output until the next bus write.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master control read zero. The vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: A read of offset 1 returns status AND enable.
- R3: A read of offset 6 returns the index of the lowest set pending bit. It returns 0xFFFFFFFF when no pending bit is set.
- R4: `irq_out` is high exactly when master bit 0 is set, at least one pending bit is set, and the output is not muted (see R11).
- R5: A write to offset 3 clears every status bit whose write-data bit is 1 and leaves the other status bits alone.
- R6: A write to offset 4 ORs the data into enable. A write to offset 5 clears the enable bits written as 1.
- R7: A write to offset 0 or 2 replaces that register with the data. A write to offset 7 stores data bits [1:0], and the upper bits read zero. Writes to offsets 1 and 6 change nothing.
- R8: A read at a word address of 8 or above returns zero. A write there changes no register.
- R9: For a level source (mask bit 0) with master bit 1 set, the status bit equals the line value sampled at the previous clock edge.
- R10: For an edge source (mask bit 1, default lines 16 to 31) with master bit 1 set, a rising edge sets the status bit one clock later. The bit stays set after the line falls, until an acknowledge or a direct write clears it.
- R11: With master bit 1 clear, request lines do not change status. A line change forces `irq_out` low from the next cycle until the next bus write.
- R12: A status write (offset 0 or 3) in the same cycle as an input event on the same bit wins over that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Request lines, already synchronous to clk |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Register updates from a bus write or a request-line change land at the next rising edge. Read data, pending, vector and `irq_out` follow the registers combinationally, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge and samples outputs 1 ns later, before the next rising edge. Its reference model advances only at the rising edge, so each comparison sees exactly the state that one edge of stimulus has produced.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int REG_COUNT  = 8;
    localparam int MAST_W     = 2;
    localparam int MAST_IRQ   = 0;
    localparam int MAST_HW    = 1;

    typedef enum logic [2:0] {
        OFF_STAT  = 3'd0,
        OFF_PEND  = 3'd1,
        OFF_EN    = 3'd2,
        OFF_ACK   = 3'd3,
        OFF_SETEN = 3'd4,
        OFF_CLREN = 3'd5,
        OFF_VEC   = 3'd6,
        OFF_MAST  = 3'd7
    } reg_off_e;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic hw_en,
    input  logic line_now,
    input  logic line_prev,
    input  logic stat_cur,
    output logic stat_next
);
    generate
        if (IS_EDGE) begin : g_edge
            always_comb stat_next = stat_cur | (hw_en & line_now & ~line_prev);
        end else begin : g_level
            logic unused_prev;
            assign unused_prev = line_prev;
            always_comb stat_next = hw_en ? line_now : stat_cur;
        end
    endgenerate
endmodule

// File: rtl/vic_lowest_index.sv
module vic_lowest_index #(
    parameter int WIDTH = 32,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 ADDR_W    = 4,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = NUM_SRC'(32'hFFFF_0000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] en;
        logic [MAST_W-1:0]  mast;
        logic               mute;
        logic [NUM_SRC-1:0] prev;
    } state_t;

    state_t st_q, st_d;

    logic               in_range;
    reg_off_e           off;
    logic [NUM_SRC-1:0] wdat;
    logic [NUM_SRC-1:0] src_next;
    logic [NUM_SRC-1:0] pend;
    logic               vec_found;
    logic [IDX_W-1:0]   vec_idx;
    logic [DATA_W-1:0]  vec_val;

    assign in_range = (bus_addr < ADDR_W'(REG_COUNT));
    assign off      = reg_off_e'(bus_addr[2:0]);
    assign wdat     = bus_wdata[NUM_SRC-1:0];

    // Per-line status next state from the request lines
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vic_src_cell #(.IS_EDGE(EDGE_MASK[g])) u_cell (
            .hw_en     (st_q.mast[MAST_HW]),
            .line_now  (irq_in[g]),
            .line_prev (st_q.prev[g]),
            .stat_cur  (st_q.stat[g]),
            .stat_next (src_next[g])
        );
    end

    assign pend = st_q.stat & st_q.en;

    vic_lowest_index #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_find (
        .req   (pend),
        .found (vec_found),
        .idx   (vec_idx)
    );

    assign vec_val = vec_found ? DATA_W'(vec_idx) : '1;

    always_comb begin
        st_d      = st_q;
        st_d.stat = src_next;
        st_d.prev = irq_in;
        if (bus_we && in_range) begin
            case (off)
                OFF_STAT:  st_d.stat = wdat;
                OFF_ACK:   st_d.stat = src_next & ~wdat;
                OFF_EN:    st_d.en   = wdat;
                OFF_SETEN: st_d.en   = st_q.en | wdat;
                OFF_CLREN: st_d.en   = st_q.en & ~wdat;
                OFF_MAST:  st_d.mast = bus_wdata[MAST_W-1:0];
                default:   ;
            endcase
        end
        if (!st_q.mast[MAST_HW] && (irq_in != st_q.prev)) begin
            st_d.mute = 1'b1;
        end else if (bus_we) begin
            st_d.mute = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (off)
                OFF_STAT: bus_rdata[NUM_SRC-1:0] = st_q.stat;
                OFF_PEND: bus_rdata[NUM_SRC-1:0] = pend;
                OFF_EN:   bus_rdata[NUM_SRC-1:0] = st_q.en;
                OFF_VEC:  bus_rdata              = vec_val;
                OFF_MAST: bus_rdata[MAST_W-1:0]  = st_q.mast;
                default:  bus_rdata              = '0;
            endcase
        end
    end

    assign irq_out = st_q.mast[MAST_IRQ] & (|pend) & ~st_q.mute;

    // Checks
    logic [NUM_SRC-1:0] below_mask;
    assign below_mask = (NUM_SRC'(1) << vec_idx) - NUM_SRC'(1);

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (pend[vec_idx] && ((pend & below_mask) == '0))); // R3
    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |-> (vec_val == '1)); // R3
    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (st_q.mast[MAST_IRQ] && (st_q.stat & st_q.en) != '0)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_ACK)) |=>
            ((st_q.stat & $past(wdat)) == '0)); // R5
    AST_SETEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SETEN)) |=>
            ((st_q.en & $past(wdat)) == $past(wdat))); // R6
    AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CLREN)) |=>
            ((st_q.en & $past(wdat)) == '0)); // R6
    AST_STAT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_STAT)) |=> (st_q.stat == $past(wdat))); // R12
    AST_HW_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mast[MAST_HW] && !(bus_we && (bus_addr == ADDR_W'(OFF_STAT) ||
                                             bus_addr == ADDR_W'(OFF_ACK))))
            |=> $stable(st_q.stat)); // R11
    AST_HW_OFF_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mast[MAST_HW] && (irq_in != st_q.prev)) |=> !irq_out); // R11
    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] EDGE_TB    = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
    logic [1:0]  m_mast = '0;
    logic        m_mute = 1'b0;
    logic [31:0] seen_rd;
    logic        seen_irq;
    logic [31:0] cur_irq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl #(.NUM_SRC(32), .DATA_W(32), .ADDR_W(4), .EDGE_MASK(EDGE_TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_stat;
            4'd1: return m_stat & m_en;
            4'd2: return m_en;
            4'd6: return lowest(m_stat & m_en);
            4'd7: return {30'd0, m_mast};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic model_irq();
        return m_mast[0] && ((m_stat & m_en) != 0) && !m_mute;
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        if (a == 4'd1) return "R2";
        if (a == 4'd6) return "R3";
        if (a >= 4'd8) return "R8";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_update(input logic we, input logic [3:0] a,
                                input logic [31:0] d, input logic [31:0] irq);
        logic [31:0] nxt = m_stat;
        if (m_mast[1]) begin
            for (int i = 0; i < 32; i++) begin
                if (EDGE_TB[i]) begin
                    if (irq[i] && !m_prev[i]) nxt[i] = 1'b1;
                end else begin
                    nxt[i] = irq[i];
                end
            end
        end
        if (!m_mast[1] && irq != m_prev) m_mute = 1'b1;
        else if (we) m_mute = 1'b0;
        if (we) begin
            case (a)
                4'd0: nxt = d;
                4'd3: nxt = nxt & ~d;
                4'd2: m_en = d;
                4'd4: m_en = m_en | d;
                4'd5: m_en = m_en & ~d;
                4'd7: m_mast = d[1:0];
                default: ;
            endcase
        end
        m_stat = nxt;
        m_prev = irq;
    endtask

    task automatic step(input logic we, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] irq);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; irq_in = irq; cur_irq = irq;
        #1;
        seen_rd  = bus_rdata;
        seen_irq = irq_out;
        chk(tag_for(a), seen_rd, model_read(a));
        chk("R4", {31'd0, seen_irq}, {31'd0, model_irq()});
        @(posedge clk);
        model_update(we, a, d, irq);
    endtask

    task automatic rd(input logic [3:0] a);
        step(1'b0, a, 32'd0, cur_irq);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, a, d, cur_irq);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a));
            chk("R1", seen_rd, (a == 6) ? 32'hFFFF_FFFF : 32'd0);
        end
        chk("R1", {31'd0, seen_irq}, 32'd0);

        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7); chk("R7", seen_rd, 32'd3);
        wr(4'd2, 32'hFFFF_FFFF);

        // R9 level source follows the line
        step(1'b0, 4'd0, 0, 32'h0000_0008);
        rd(4'd0); chk("R9", seen_rd, 32'h8);
        rd(4'd6); chk("R3", seen_rd, 32'd3);
        chk("R4", {31'd0, seen_irq}, 32'd1);
        step(1'b0, 4'd0, 0, 32'h0);
        rd(4'd0); chk("R9", seen_rd, 32'h0);

        // R10 edge source latches
        step(1'b0, 4'd0, 0, 32'h0010_0000);
        step(1'b0, 4'd0, 0, 32'h0);
        rd(4'd0); chk("R10", seen_rd, 32'h0010_0000);
        rd(4'd6); chk("R3", seen_rd, 32'd20);
        wr(4'd3, 32'h0010_0000);
        rd(4'd0); chk("R5", seen_rd, 32'h0);

        // R12 ack in same cycle as a rising edge
        step(1'b1, 4'd3, 32'h0020_0000, 32'h0020_0000);
        rd(4'd0); chk("R12", seen_rd, 32'h0);
        step(1'b0, 4'd0, 0, 32'h0);

        // R6 set/clear enable aliases
        wr(4'd5, 32'h0000_FFFF);
        rd(4'd2); chk("R6", seen_rd, 32'hFFFF_0000);
        wr(4'd4, 32'h0000_0001);
        rd(4'd2); chk("R6", seen_rd, 32'hFFFF_0001);

        // R7 read-only offsets ignore writes
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1); chk("R7", seen_rd, 32'h0);
        wr(4'd6, 32'h0);
        rd(4'd6); chk("R7", seen_rd, 32'hFFFF_FFFF);

        // R8 out of range
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd9); chk("R8", seen_rd, 32'h0);
        rd(4'd2); chk("R8", seen_rd, 32'hFFFF_0001);

        // R11 hardware inputs disabled
        wr(4'd7, 32'h1);
        wr(4'd0, 32'h1);
        rd(4'd0); chk("R11", {31'd0, seen_irq}, 32'd1);
        step(1'b0, 4'd0, 0, 32'h0000_0020);
        rd(4'd0); chk("R11", seen_rd, 32'h1);
        chk("R11", {31'd0, seen_irq}, 32'd0);
        wr(4'd9, 32'h0);
        rd(4'd0); chk("R11", {31'd0, seen_irq}, 32'd1);
        step(1'b0, 4'd0, 0, 32'h0);
        wr(4'd9, 32'h0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic        we;
            logic [3:0]  a;
            logic [31:0] d;
            logic [31:0] irq;
            we  = ($urandom % 3) == 0;
            a   = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % 8);
            d   = $urandom;
            if (a == 4'd7 && ($urandom % 4 != 0)) d[1] = 1'b1;
            irq = cur_irq;
            if ($urandom % 2 == 0) irq = irq ^ (32'd1 << ($urandom % 32));
            step(we, a, d, irq);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule